// File: doc/BRIEF.md
# Block-Based Memory Security Filter

This block sits between an upstream bus master and a downstream memory and decides, one transaction at a time, whether a single-beat read or write may pass. The address space is cut into fixed-size blocks. Each block owns one configuration bit, and the bits are packed 32 to a lookup word. A bit of 1 opens the block to non-secure traffic only. A bit of 0 opens it to secure traffic only. Secure traffic has no extra privilege over non-secure blocks. A passing access is forwarded downstream unchanged, one cycle after it is presented. A failing access never reaches the memory. It completes with an error and zero read data, and it sets a sticky status flag that can raise an interrupt.

Software programs the table through a small register interface. An index register selects a lookup word. A data register reads or replaces that word. A full-width write to the data register moves the index forward by one, so the whole table can be loaded with one index write followed by a stream of data writes. A status register, an enable register and a clear register control the interrupt.

Top module: `blk_sec_filter`

## Requirements
- R1: The block number is `up_addr[ADDR_W-1:OFF_W]`, where OFF_W = log2(BLK_BYTES); the defaults are 256-byte blocks and 8 lookup words. Bit i of lookup word n governs block n*32+i.
- R2: A transaction passes when its block's bit equals `up_nonsec` (1 = non-secure). A passing transaction appears on `dn_valid/dn_write/dn_addr/dn_wdata` one cycle later. In that same cycle `up_resp_valid`=1, `up_err`=0, and a read returns `dn_rdata` on `up_rdata`.
- R3: A transaction whose block bit differs from `up_nonsec` is blocked. One cycle later `up_resp_valid`=1, `up_err`=1, `up_rdata`=0 and `dn_valid`=0.
- R4: A register write to offset 0 (index) sets the index to the written value modulo LUT_WORDS. A read of offset 0 returns the index.
- R5: A register write to offset 1 (lookup data) replaces the word at the index. With `reg_full`=1 the index then advances by one, wrapping from LUT_WORDS-1 to 0. With `reg_full`=0 the index is unchanged.
- R6: A read of offset 1 returns the word at the index and does not move the index. Register read data is valid on `reg_rdata` one cycle after `reg_ren`.
- R7: A blocked transaction sets the sticky status bit (offset 2, bit 0). Writing 1 to bit 0 of offset 4 clears it, and writing 0 there has no effect. If a block and a clear happen in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when the status bit and the enable bit (offset 3, bit 0, read/write) are both 1.
- R9: A lookup write takes effect from the next cycle for both security worlds. A transaction presented in the same cycle as the write still uses the old bit.
- R10: Reset (synchronous, active high) clears every lookup bit, the index, the status bit and the enable bit. It also drives `dn_valid`, `up_resp_valid` and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream transaction request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_nonsec | input | 1 | 1 = non-secure transaction |
| up_addr | input | ADDR_W | Transaction byte address |
| up_wdata | input | 32 | Write data |
| up_resp_valid | output | 1 | Response valid, one cycle after request |
| up_err | output | 1 | 1 = access was blocked |
| up_rdata | output | 32 | Read data, zero when blocked |
| dn_valid | output | 1 | Forwarded request to memory |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | ADDR_W | Forwarded address |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Memory read data for the forwarded request |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset (0 index, 1 lookup data, 2 status, 3 enable, 4 clear) |
| reg_wdata | input | 32 | Register write data |
| reg_full | input | 1 | 1 = full 32-bit write |
| reg_rdata | output | 32 | Register read data, one cycle after reg_ren |
| irq | output | 1 | Interrupt |

## Verification
The in-RTL properties check several rules on every cycle. A request that matches its block bit must be forwarded with its address. A mismatched one must come back as an error with no downstream request and zero data. The index stays in range and holds on partial writes. The status bit stays set until a clear is written, and the interrupt never rises without the enable. Some behaviour only the bench scenarios can show. These include the mapping from address to word and bit across the table and the modulo and wrap of the index. They also include a table change taking effect on the very next cycle while a same-cycle request still sees the old bit, and a block winning over a simultaneous clear.

// File: rtl/bsf_pkg.sv
package bsf_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RS_INDEX  = 3'd0,
    RS_WORD   = 3'd1,
    RS_STATUS = 3'd2,
    RS_ENABLE = 3'd3,
    RS_CLEAR  = 3'd4
  } reg_sel_e;

  localparam int WORD_BITS = 32;
  localparam int BIT_SEL_W = 5;
endpackage

// File: rtl/bsf_table.sv
module bsf_table #(
  parameter int LUT_WORDS = 8,
  localparam int WIDX_W = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1,
  localparam int SEL_W  = WIDX_W + bsf_pkg::BIT_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_we,
  input  logic              word_we,
  input  logic              wr_full,
  input  logic [31:0]       wr_data,
  input  logic [SEL_W-1:0]  blk_sel,
  output logic              cfg_bit,
  output logic [WIDX_W-1:0] cur_idx,
  output logic [31:0]       cur_word
);
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(LUT_WORDS - 1);

  logic [31:0]       mem_q [LUT_WORDS];
  logic [WIDX_W-1:0] idx_q;
  logic [31:0]       look_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LUT_WORDS; k++) mem_q[k] <= '0;
    end else if (word_we) begin
      mem_q[idx_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= WIDX_W'(wr_data % LUT_WORDS);
    end else if (word_we && wr_full) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    look_word = mem_q[blk_sel[SEL_W-1:bsf_pkg::BIT_SEL_W]];
    cfg_bit   = look_word[blk_sel[bsf_pkg::BIT_SEL_W-1:0]];
  end

  assign cur_idx  = idx_q;
  assign cur_word = mem_q[idx_q];

  // R4: index never leaves the table
  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    32'(idx_q) < LUT_WORDS);

  // R5: partial word write leaves the index where it was
  p_partial_hold_r5: assert property (@(posedge clk) disable iff (rst)
    word_we && !wr_full |=> idx_q == $past(idx_q));

  // R5: full word write moves the index
  p_full_moves_r5: assert property (@(posedge clk) disable iff (rst)
    word_we && wr_full && (LUT_WORDS > 1) |=> idx_q != $past(idx_q));
endmodule

// File: rtl/bsf_gate.sv
module bsf_gate #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              up_nonsec,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  input  logic              cfg_bit,
  output logic              blocked,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  output logic              resp_valid,
  output logic              resp_err
);
  logic allow;

  assign allow   = (cfg_bit == up_nonsec);
  assign blocked = up_valid && !allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid   <= 1'b0;
      dn_write   <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
    end else begin
      dn_valid   <= up_valid && allow;
      resp_valid <= up_valid;
      resp_err   <= up_valid && !allow;
      if (up_valid && allow) begin
        dn_write <= up_write;
        dn_addr  <= up_addr;
        dn_wdata <= up_wdata;
      end
    end
  end

  // R2: matching world is forwarded with its address, no error
  p_pass_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    up_valid && (cfg_bit == up_nonsec)
      |=> dn_valid && resp_valid && !resp_err && dn_addr == $past(up_addr));

  // R3: mismatching world is stopped and answered with an error
  p_block_stop_r3: assert property (@(posedge clk) disable iff (rst)
    up_valid && (cfg_bit != up_nonsec) |=> !dn_valid && resp_valid && resp_err);
endmodule

// File: rtl/bsf_intr.sv
module bsf_intr (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic en_we,
  input  logic clr_we,
  input  logic wbit,
  output logic stat,
  output logic en,
  output logic irq
);
  logic stat_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (hit)                 stat_q <= 1'b1;
      else if (clr_we && wbit) stat_q <= 1'b0;
      if (en_we)               en_q   <= wbit;
    end
  end

  assign stat = stat_q;
  assign en   = en_q;
  assign irq  = stat_q && en_q;

  // R7: a blocked access always leaves the status set
  p_hit_sets_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> stat_q);

  // R7: status only drops on a clear write of 1
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    stat_q && !(clr_we && wbit) |=> stat_q);

  // R8: no interrupt while disabled
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq);
endmodule

// File: rtl/blk_sec_filter.sv
module blk_sec_filter #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 256,
  parameter int LUT_WORDS = 8,
  localparam int OFF_W  = $clog2(BLK_BYTES),
  localparam int WIDX_W = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1,
  localparam int SEL_W  = WIDX_W + bsf_pkg::BIT_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              up_nonsec,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [31:0]       up_wdata,
  output logic              up_resp_valid,
  output logic              up_err,
  output logic [31:0]       up_rdata,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_full,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  import bsf_pkg::*;

  logic              idx_we, word_we, en_we, clr_we;
  logic              cfg_bit, blocked, stat, en;
  logic [WIDX_W-1:0] cur_idx;
  logic [31:0]       cur_word;
  logic [SEL_W-1:0]  blk_sel;
  logic              resp_valid, resp_err;

  assign blk_sel = up_addr[OFF_W +: SEL_W];

  assign idx_we  = reg_wen && (reg_addr == RS_INDEX);
  assign word_we = reg_wen && (reg_addr == RS_WORD);
  assign en_we   = reg_wen && (reg_addr == RS_ENABLE);
  assign clr_we  = reg_wen && (reg_addr == RS_CLEAR);

  bsf_table #(.LUT_WORDS(LUT_WORDS)) u_table (
    .clk(clk), .rst(rst),
    .idx_we(idx_we), .word_we(word_we), .wr_full(reg_full), .wr_data(reg_wdata),
    .blk_sel(blk_sel), .cfg_bit(cfg_bit),
    .cur_idx(cur_idx), .cur_word(cur_word)
  );

  bsf_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_write(up_write), .up_nonsec(up_nonsec),
    .up_addr(up_addr), .up_wdata(up_wdata), .cfg_bit(cfg_bit),
    .blocked(blocked),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err)
  );

  bsf_intr u_intr (
    .clk(clk), .rst(rst),
    .hit(blocked), .en_we(en_we), .clr_we(clr_we), .wbit(reg_wdata[0]),
    .stat(stat), .en(en), .irq(irq)
  );

  assign up_resp_valid = resp_valid;
  assign up_err        = resp_err;
  assign up_rdata      = (resp_valid && !resp_err) ? dn_rdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_ren) begin
      case (reg_addr)
        RS_INDEX:  reg_rdata <= 32'(cur_idx);
        RS_WORD:   reg_rdata <= cur_word;
        RS_STATUS: reg_rdata <= {31'd0, stat};
        RS_ENABLE: reg_rdata <= {31'd0, en};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  // R3: a blocked response never carries data
  p_blk_zero_r3: assert property (@(posedge clk) disable iff (rst)
    up_resp_valid && up_err |-> up_rdata == '0);

  // R2: every forwarded request has a matching clean response
  p_fwd_resp_r2: assert property (@(posedge clk) disable iff (rst)
    dn_valid |-> up_resp_valid && !up_err);
endmodule

// File: tb/blk_sec_filter_tb.sv
module blk_sec_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        up_valid = 0, up_write = 0, up_nonsec = 0;
  logic [15:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic        up_resp_valid, up_err;
  logic [31:0] up_rdata;
  logic        dn_valid, dn_write;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata, dn_rdata;
  logic        reg_wen = 0, reg_ren = 0, reg_full = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign dn_rdata = {16'hC0DE, dn_addr};

  blk_sec_filter u_dut (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_write(up_write), .up_nonsec(up_nonsec),
    .up_addr(up_addr), .up_wdata(up_wdata),
    .up_resp_valid(up_resp_valid), .up_err(up_err), .up_rdata(up_rdata),
    .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata),
    .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_full(reg_full), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  localparam logic [2:0] A_IDX = 3'd0, A_WORD = 3'd1, A_STAT = 3'd2,
                         A_EN = 3'd3, A_CLR = 3'd4;

  localparam logic [31:0] PROG [8] = '{32'h0000FFFF, 32'hAAAAAAAA, 32'h0, 32'h0,
                                       32'h0, 32'h0, 32'h0, 32'h80000001};

  // {write, nonsec, addr, expect_error}
  localparam logic [18:0] VEC [16] = '{
    {1'b0, 1'b1, 16'h0310, 1'b0}, {1'b0, 1'b0, 16'h0310, 1'b1},
    {1'b1, 1'b0, 16'h1400, 1'b0}, {1'b0, 1'b1, 16'h1400, 1'b1},
    {1'b0, 1'b1, 16'h2100, 1'b0}, {1'b1, 1'b0, 16'h2100, 1'b1},
    {1'b0, 1'b0, 16'h2000, 1'b0}, {1'b0, 1'b1, 16'hFFFC, 1'b0},
    {1'b0, 1'b0, 16'hFFFC, 1'b1}, {1'b1, 1'b1, 16'hE000, 1'b0},
    {1'b0, 1'b0, 16'hE1FF, 1'b0}, {1'b1, 1'b1, 16'hE1FF, 1'b1},
    {1'b0, 1'b0, 16'h6400, 1'b0}, {1'b0, 1'b1, 16'h6400, 1'b1},
    {1'b0, 1'b1, 16'h0F00, 1'b0}, {1'b0, 1'b1, 16'h1000, 1'b1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d, logic full);
    @(negedge clk);
    reg_wen = 1; reg_addr = a; reg_wdata = d; reg_full = full;
    @(negedge clk);
    reg_wen = 0; reg_full = 0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_ren = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata; reg_ren = 0;
  endtask

  task automatic drive(logic wr, logic ns, logic [15:0] a);
    up_valid = 1; up_write = wr; up_nonsec = ns; up_addr = a; up_wdata = {a, ~a};
  endtask

  task automatic judge(string tag, logic wr, logic [15:0] a, logic exp_err);
    chk({tag, " resp_valid"}, 32'(up_resp_valid), 32'd1);
    chk({tag, " err"}, 32'(up_err), 32'(exp_err));
    chk({tag, " dn_valid"}, 32'(dn_valid), 32'(!exp_err));
    if (!exp_err) begin
      chk({tag, " dn_addr"}, 32'(dn_addr), 32'(a));
      chk({tag, " dn_write"}, 32'(dn_write), 32'(wr));
      if (wr) chk({tag, " dn_wdata"}, dn_wdata, {a, ~a});
    end
    if (!wr) chk({tag, " rdata"}, up_rdata, exp_err ? 32'd0 : {16'hC0DE, a});
  endtask

  task automatic xact(string tag, logic wr, logic ns, logic [15:0] a, logic exp_err);
    @(negedge clk);
    drive(wr, ns, a);
    @(negedge clk);
    judge(tag, wr, a, exp_err);
    up_valid = 0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    chk("R10 dn_valid", 32'(dn_valid), 32'd0);
    chk("R10 resp_valid", 32'(up_resp_valid), 32'd0);
    chk("R10 irq", 32'(irq), 32'd0);
    reg_rd(A_IDX, d);  chk("R10 index", d, 32'd0);
    reg_rd(A_WORD, d); chk("R10 word0", d, 32'd0);
    reg_rd(A_STAT, d); chk("R10 status", d, 32'd0);
    reg_rd(A_EN, d);   chk("R10 enable", d, 32'd0);
    xact("R10 secure after reset", 1'b0, 1'b0, 16'h4321, 1'b0);
    xact("R10 nonsec after reset", 1'b0, 1'b1, 16'h4321, 1'b1);
    reg_wr(A_CLR, 32'd1, 1);

    // R5: load whole table with full writes, index wraps to 0
    reg_wr(A_IDX, 32'd0, 1);
    for (int k = 0; k < 8; k++) reg_wr(A_WORD, PROG[k], 1);
    reg_rd(A_IDX, d);  chk("R5 wrap index", d, 32'd0);
    // R6: data read does not advance
    reg_rd(A_WORD, d); chk("R6 word read", d, PROG[0]);
    reg_rd(A_IDX, d);  chk("R6 index held", d, 32'd0);

    // R1 R2 R3: vector walk
    for (int v = 0; v < 16; v++)
      xact($sformatf("R1/R2/R3 vec%0d", v), VEC[v][18], VEC[v][17], VEC[v][16:1], VEC[v][0]);

    // R7 R8: status set, irq gated by enable
    reg_rd(A_STAT, d); chk("R7 status set", d, 32'd1);
    chk("R8 irq disabled", 32'(irq), 32'd0);
    reg_wr(A_EN, 32'd1, 1);
    chk("R8 irq enabled", 32'(irq), 32'd1);
    reg_wr(A_CLR, 32'd0, 1);
    reg_rd(A_STAT, d); chk("R7 clear with 0 ignored", d, 32'd1);
    reg_wr(A_CLR, 32'd1, 1);
    reg_rd(A_STAT, d); chk("R7 cleared", d, 32'd0);
    chk("R8 irq after clear", 32'(irq), 32'd0);
    // R7: block and clear in same cycle -> set
    @(negedge clk);
    drive(1'b0, 1'b0, 16'h0310);
    reg_wen = 1; reg_addr = A_CLR; reg_wdata = 32'd1;
    @(negedge clk);
    up_valid = 0; reg_wen = 0;
    reg_rd(A_STAT, d); chk("R7 block wins over clear", d, 32'd1);
    chk("R8 irq on", 32'(irq), 32'd1);
    reg_wr(A_CLR, 32'd1, 1);
    reg_wr(A_EN, 32'd0, 1);

    // R4: index modulo
    reg_wr(A_IDX, 32'd13, 1);
    reg_rd(A_IDX, d);  chk("R4 index mod", d, 32'd5);
    reg_rd(A_WORD, d); chk("R6 word5", d, 32'd0);
    // R5: partial write keeps index
    reg_wr(A_WORD, 32'h12340000, 0);
    reg_rd(A_IDX, d);  chk("R5 partial index", d, 32'd5);
    reg_rd(A_WORD, d); chk("R5 partial data", d, 32'h12340000);
    reg_wr(A_IDX, 32'd7, 1);
    reg_wr(A_WORD, PROG[7], 1);
    reg_rd(A_IDX, d);  chk("R5 wrap from last", d, 32'd0);

    // R9: change effective next cycle, old bit same cycle
    @(negedge clk);
    reg_wen = 1; reg_addr = A_WORD; reg_wdata = 32'h0000FFF7; reg_full = 0;
    @(negedge clk);
    reg_wen = 0;
    drive(1'b0, 1'b0, 16'h0300);
    @(negedge clk);
    judge("R9 next-cycle secure", 1'b0, 16'h0300, 1'b0);
    up_valid = 0;
    xact("R9 nonsec now blocked", 1'b0, 1'b1, 16'h0300, 1'b1);
    @(negedge clk);
    reg_wen = 1; reg_addr = A_WORD; reg_wdata = 32'h0000FFFF; reg_full = 0;
    drive(1'b0, 1'b0, 16'h0300);
    @(negedge clk);
    judge("R9 same-cycle old bit", 1'b0, 16'h0300, 1'b0);
    reg_wen = 0; up_valid = 0;
    xact("R9 secure after restore", 1'b0, 1'b0, 16'h0300, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule